// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, called A and B, with one path for each direction. Each path has its own capture register and its own 2:1 source selector. A path either forwards the opposite bus's live input straight through (real-time mode), or it drives the value held in its own register (stored mode). The signals are never inverted. Each bus is modelled as three separate signals: an input value, an output value and an output-enable. A one-bit input per bus tells the block whether some external agent is also driving that bus. This lets the block report contention and resolve the bus-hold loop without any tri-state nets.

The A-to-B register samples the A bus on every rising edge of its own clock. The B-to-A register samples the B bus on every rising edge of the other clock. Neither capture depends on the selects or the enables. A register therefore sees the value this block is itself putting on that bus, whenever the block drives it. When both directions are enabled in real-time mode, the two paths would feed each other. That loop is resolved by a registered keeper, so the held value is deterministic. Each clock domain has its own reset synchronizer. The active-low reset clears all state at once, and its release is synchronous.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On every rising edge of `clk_ab` after reset release, the A-to-B register loads the value on the A bus, whatever `sel_ab` and `en_ab` are. The value on the A bus is `a_out` when `a_oe` is 1, and `a_in` otherwise.
- R2: On every rising edge of `clk_ba` after reset release, the B-to-A register loads the value on the B bus, whatever the selects and enables are. The value on the B bus is `b_out` when `b_oe` is 1, and `b_in` otherwise.
- R3: `b_oe` equals `en_ab` (active high). While `en_ab` is 0, `b_out` is all zeros.
- R4: `a_oe` equals the inverse of `en_ba_n` (active low). While `en_ba_n` is 1, `a_out` is all zeros.
- R5: With `en_ab`=1, `sel_ab`=0 and the A side not driven by the block, `b_out` equals `a_in`. The mirror case holds for `a_out` and `b_in`.
- R6: With `en_ab`=1 and `sel_ab`=1, `b_out` equals the A-to-B register. With `en_ba_n`=0 and `sel_ba`=1, `a_out` equals the B-to-A register. Both can hold at the same time.
- R7: When the B bus is driven in real time from the A input, a `clk_ba` edge loads the A data into the B-to-A register, so A is stored in both registers. The mirror case stores B in both registers.
- R8: Hold mode is both directions enabled with both selects at 0. In hold mode, `a_out` and `b_out` both equal the hold value. The hold value is `a_in` if `a_ext_oe` is 1. Otherwise it is `b_in` if `b_ext_oe` is 1. Otherwise it is the keeper register.
- R9: On each `clk_ab` edge, the keeper loads `a_in` if `a_ext_oe` is 1, else `b_in` if `b_ext_oe` is 1. If neither external driver is active, the keeper holds its value. Reset clears the keeper to zero.
- R10: `contention` is 1 exactly when (`a_oe` and `a_ext_oe`) or (`b_oe` and `b_ext_oe`).
- R11: `rst_n` low clears both capture registers and the keeper at once, with no clock edge needed.
- R12: After `rst_n` rises, a register does not load on the first two edges of its clock. It first loads on the third edge.
- R13: Chained mode is B driven in real time while the A side is driven from the B-to-A register (`en_ab`=1, `sel_ab`=0, `en_ba_n`=0, `sel_ba`=1). In chained mode, `b_out` equals the B-to-A register. The mirror case holds as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B register and the keeper |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_ab | input | 1 | Drive enable for the B bus, active high |
| en_ba_n | input | 1 | Drive enable for the A bus, active low |
| sel_ab | input | 1 | B bus source: 0 live A, 1 stored register |
| sel_ba | input | 1 | A bus source: 0 live B, 1 stored register |
| a_ext_oe | input | 1 | External agent is driving the A bus |
| b_ext_oe | input | 1 | External agent is driving the B bus |
| a_in | input | WIDTH | Value present on the A bus from outside |
| b_in | input | WIDTH | Value present on the B bus from outside |
| a_out | output | WIDTH | Value the block drives onto the A bus |
| a_oe | output | 1 | Block drives the A bus |
| b_out | output | WIDTH | Value the block drives onto the B bus |
| b_oe | output | 1 | Block drives the B bus |
| contention | output | 1 | Block and an external agent drive the same bus |

## Verification
The hardest state to reach from the ports is hold mode with no external driver. In that state the outputs depend only on a keeper value that was loaded on an earlier `clk_ab` edge. The stimulus first enters hold mode with the A side driven externally and pulses `clk_ab`. It then releases both external drivers and pulses both clocks, and checks that the outputs and both registers keep the old value. Individual clock pulses are gated per vector. This lets the bench reach the store-one-hold-other cases, the store-into-both case, and the three-edge reset release.

// File: rtl/dual_reg_xcvr_pkg.sv
`timescale 1ns/1ps
package dual_reg_xcvr_pkg;
  // Source chosen for one direction's output.
  typedef enum logic [2:0] {
    PATH_OFF,     // direction not driving
    PATH_LIVE,    // live input of the opposite bus
    PATH_STORED,  // this direction's own register
    PATH_CHAIN,   // opposite bus is driven from the peer register
    PATH_HOLD     // both paths real-time: keeper resolves the loop
  } path_src_e;
endpackage

// File: rtl/dual_reg_xcvr_rst_sync.sv
`timescale 1ns/1ps
module dual_reg_xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_next;

  always_comb begin
    sync_next = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_next;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dual_reg_xcvr_cap_reg.sv
`timescale 1ns/1ps
module dual_reg_xcvr_cap_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] q_next;

  always_comb begin
    q_next = load ? d : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_next;
  end

  assign q = q_q;
endmodule

// File: rtl/dual_reg_xcvr_dir.sv
`timescale 1ns/1ps
module dual_reg_xcvr_dir
  import dual_reg_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             drive_en,
  input  logic             sel_stored,
  input  logic             peer_drive,
  input  logic             peer_stored,
  input  logic [WIDTH-1:0] live_val,
  input  logic [WIDTH-1:0] own_q,
  input  logic [WIDTH-1:0] peer_q,
  input  logic [WIDTH-1:0] hold_val,
  output logic [WIDTH-1:0] out_val,
  output path_src_e        src
);
  always_comb begin
    if (!drive_en)        src = PATH_OFF;
    else if (sel_stored)  src = PATH_STORED;
    else if (!peer_drive) src = PATH_LIVE;
    else if (peer_stored) src = PATH_CHAIN;
    else                  src = PATH_HOLD;
  end

  always_comb begin
    unique case (src)
      PATH_LIVE:   out_val = live_val;
      PATH_STORED: out_val = own_q;
      PATH_CHAIN:  out_val = peer_q;
      PATH_HOLD:   out_val = hold_val;
      default:     out_val = '0;
    endcase
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
`timescale 1ns/1ps
module dual_reg_xcvr
  import dual_reg_xcvr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst_n,
  input  logic             en_ab,
  input  logic             en_ba_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             a_ext_oe,
  input  logic             b_ext_oe,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic             contention
);
  logic             rst_ab_n;
  logic             rst_ba_n;
  logic [WIDTH-1:0] ab_q;
  logic [WIDTH-1:0] ba_q;
  logic [WIDTH-1:0] keep_q;
  logic [WIDTH-1:0] ab_d;
  logic [WIDTH-1:0] ba_d;
  logic [WIDTH-1:0] hold_val;
  logic             keep_load;
  path_src_e        src_b;
  path_src_e        src_a;

  // Per-domain reset release
  dual_reg_xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_ab (
    .clk(clk_ab), .rst_n(rst_n), .rst_sync_n(rst_ab_n));
  dual_reg_xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_ba (
    .clk(clk_ba), .rst_n(rst_n), .rst_sync_n(rst_ba_n));

  // Drive enables of the two buses
  always_comb begin
    b_oe = en_ab;
    a_oe = !en_ba_n;
  end

  // Loop resolution value and keeper load enable
  always_comb begin
    keep_load = a_ext_oe | b_ext_oe;
    if (a_ext_oe)      hold_val = a_in;
    else if (b_ext_oe) hold_val = b_in;
    else               hold_val = keep_q;
  end

  dual_reg_xcvr_dir #(.WIDTH(WIDTH)) u_dir_b (
    .drive_en(b_oe), .sel_stored(sel_ab), .peer_drive(a_oe),
    .peer_stored(sel_ba), .live_val(a_in), .own_q(ab_q), .peer_q(ba_q),
    .hold_val(hold_val), .out_val(b_out), .src(src_b));

  dual_reg_xcvr_dir #(.WIDTH(WIDTH)) u_dir_a (
    .drive_en(a_oe), .sel_stored(sel_ba), .peer_drive(b_oe),
    .peer_stored(sel_ab), .live_val(b_in), .own_q(ba_q), .peer_q(ab_q),
    .hold_val(hold_val), .out_val(a_out), .src(src_a));

  // Registers see whatever is on their bus, including the block's own drive
  always_comb begin
    ab_d       = a_oe ? a_out : a_in;
    ba_d       = b_oe ? b_out : b_in;
    contention = (a_oe & a_ext_oe) | (b_oe & b_ext_oe);
  end

  dual_reg_xcvr_cap_reg #(.WIDTH(WIDTH)) u_reg_ab (
    .clk(clk_ab), .rst_n(rst_ab_n), .load(1'b1), .d(ab_d), .q(ab_q));
  dual_reg_xcvr_cap_reg #(.WIDTH(WIDTH)) u_reg_ba (
    .clk(clk_ba), .rst_n(rst_ba_n), .load(1'b1), .d(ba_d), .q(ba_q));
  dual_reg_xcvr_cap_reg #(.WIDTH(WIDTH)) u_keep (
    .clk(clk_ab), .rst_n(rst_ab_n), .load(keep_load), .d(hold_val), .q(keep_q));
endmodule

// File: rtl/dual_reg_xcvr_chk.sv
`timescale 1ns/1ps
module dual_reg_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             rst_n,
  input logic             rst_ab_n,
  input logic             rst_ba_n,
  input logic             en_ab,
  input logic             en_ba_n,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic             a_ext_oe,
  input logic             b_ext_oe,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             contention,
  input logic [WIDTH-1:0] ab_q,
  input logic [WIDTH-1:0] ba_q,
  input logic [WIDTH-1:0] keep_q
);
  AST_CAPTURE_A: assert property (@(posedge clk_ab) disable iff (!rst_ab_n)
    (rst_ab_n && !a_oe) |=> (ab_q == $past(a_in)));                    // R1
  AST_CAPTURE_B: assert property (@(posedge clk_ba) disable iff (!rst_ba_n)
    (rst_ba_n && !b_oe) |=> (ba_q == $past(b_in)));                    // R2
  AST_B_QUIET: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !en_ab |-> (!b_oe && b_out == '0));                                // R3
  AST_A_QUIET: assert property (@(posedge clk_ba) disable iff (!rst_n)
    en_ba_n |-> (!a_oe && a_out == '0));                               // R4
  AST_LIVE_A2B: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (en_ab && !sel_ab && en_ba_n) |-> (b_out == a_in));                // R5
  AST_STORED_A2B: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (en_ab && sel_ab) |-> (b_out == ab_q));                            // R6
  AST_HOLD_KEEP: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (en_ab && !en_ba_n && !sel_ab && !sel_ba && !a_ext_oe && !b_ext_oe)
    |-> (a_out == keep_q && b_out == keep_q));                         // R8
  AST_KEEP_STABLE: assert property (@(posedge clk_ab) disable iff (!rst_ab_n)
    (rst_ab_n && !a_ext_oe && !b_ext_oe) |=> $stable(keep_q));         // R9
  AST_CONTEND_B: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (en_ab && b_ext_oe) |-> contention);                               // R10
endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
  .rst_ab_n(rst_ab_n), .rst_ba_n(rst_ba_n),
  .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .a_ext_oe(a_ext_oe), .b_ext_oe(b_ext_oe), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
  .contention(contention), .ab_q(ab_q), .ba_q(ba_q), .keep_q(keep_q));

// File: tb/dual_reg_xcvr_bench.sv
`timescale 1ns/1ps
module dual_reg_xcvr_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic g_ab, g_ba;
  logic clk_ab, clk_ba;
  logic rst_n, en_ab, en_ba_n, sel_ab, sel_ba, a_ext_oe, b_ext_oe;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe, contention;

  always #2.5 clk = ~clk;
  assign clk_ab = clk & g_ab;
  assign clk_ba = clk & g_ba;

  dual_reg_xcvr #(.WIDTH(W)) u_dual_reg_xcvr (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .en_ab(en_ab),
    .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_ext_oe(a_ext_oe), .b_ext_oe(b_ext_oe), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .contention(contention));

  typedef struct packed {
    logic en_ab, en_ba_n, sel_ab, sel_ba, a_ext, b_ext, p_ab, p_ba;
    logic [7:0] a, b;
    logic x_aoe, x_boe, x_cont;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'hA5, 8'h3C, 1'b0,1'b0,1'b0}, // R1 R2 isolate, store both
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 8'h11, 8'h22, 1'b0,1'b0,1'b0}, // R1 store A hold B
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hFF, 8'h00, 1'b0,1'b1,1'b0}, // R6 stored A to B
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 8'h5A, 8'h00, 1'b0,1'b1,1'b0}, // R5 R7 A in both
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 8'h00, 8'hC3, 1'b1,1'b0,1'b0}, // R5 R7 B in both
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h77, 1'b1,1'b0,1'b0}, // R6 stored B to A
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h00, 1'b1,1'b1,1'b0}, // R6 both stored
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'h01, 8'h02, 1'b0,1'b1,1'b1}, // R10 B contention
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 8'h96, 8'h00, 1'b1,1'b1,1'b1}, // R8 R9 hold, A driven
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00, 8'h00, 1'b1,1'b1,1'b0}, // R8 R9 hold, undriven
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 8'h00, 8'h4B, 1'b1,1'b1,1'b1}, // R8 hold, B driven
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h00, 1'b1,1'b1,1'b0}, // R13 chained
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 8'h0F, 8'hF0, 1'b0,1'b0,1'b0}, // R1 R2 select ignored
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h00, 1'b0,1'b1,1'b0}  // R1 R6 readback
  };

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] m_ab, m_ba, m_keep;

  function automatic string vtag(int i);
    case (i)
      0, 1:   return "R1";
      2, 5, 6: return "R6";
      3, 4:   return "R7";
      7:      return "R10";
      8, 9, 10: return "R8";
      11:     return "R13";
      12:     return "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model of the outputs from the requirements
  function automatic logic [W-1:0] hold_ref();
    if (a_ext_oe)      return a_in;
    else if (b_ext_oe) return b_in;
    else               return m_keep;
  endfunction

  function automatic logic [W-1:0] bout_ref();
    if (!en_ab)                                   return '0;
    if (sel_ab)                                   return m_ab;
    if (en_ba_n)                                  return a_in;
    if (sel_ba)                                   return m_ba;
    return hold_ref();
  endfunction

  function automatic logic [W-1:0] aout_ref();
    if (en_ba_n)                                  return '0;
    if (sel_ba)                                   return m_ba;
    if (!en_ab)                                   return b_in;
    if (sel_ab)                                   return m_ab;
    return hold_ref();
  endfunction

  task automatic run_vec(int i);
    logic [W-1:0] d_ab, d_ba, d_keep;
    vec_t v = VECS[i];
    en_ab = v.en_ab; en_ba_n = v.en_ba_n; sel_ab = v.sel_ab; sel_ba = v.sel_ba;
    a_ext_oe = v.a_ext; b_ext_oe = v.b_ext; a_in = v.a; b_in = v.b;
    g_ab = v.p_ab; g_ba = v.p_ba;
    #0.5;
    d_ab   = en_ba_n ? a_in : aout_ref();
    d_ba   = en_ab ? bout_ref() : b_in;
    d_keep = hold_ref();
    @(posedge clk);
    if (v.p_ab) begin m_ab = d_ab; m_keep = d_keep; end
    if (v.p_ba) m_ba = d_ba;
    @(negedge clk);
    g_ab = 1'b0; g_ba = 1'b0;
    chk("R4 a_oe", {7'b0, a_oe}, {7'b0, v.x_aoe});
    chk("R3 b_oe", {7'b0, b_oe}, {7'b0, v.x_boe});
    chk("R10 contention", {7'b0, contention}, {7'b0, v.x_cont});
    chk({vtag(i), " a_out"}, a_out, aout_ref());
    chk({vtag(i), " b_out"}, b_out, bout_ref());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; g_ab = 1'b1; g_ba = 1'b1;
    en_ab = 1'b0; en_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
    a_ext_oe = 1'b0; b_ext_oe = 1'b0; a_in = '0; b_in = '0;
    m_ab = '0; m_ba = '0; m_keep = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    g_ab = 1'b0; g_ba = 1'b0;
    // Reset state
    chk("R3 reset b_oe", {7'b0, b_oe}, 8'h00);
    chk("R4 reset a_oe", {7'b0, a_oe}, 8'h00);
    chk("R3 reset b_out", b_out, 8'h00);
    chk("R11 reset contention", {7'b0, contention}, 8'h00);
    // Keeper is zero after reset (hold mode, undriven)
    en_ab = 1'b1; en_ba_n = 1'b0;
    #0.5;
    chk("R9 keeper reset a_out", a_out, 8'h00);
    chk("R9 keeper reset b_out", b_out, 8'h00);
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R11: asynchronous clear, R12: synchronous release
    en_ab = 1'b1; sel_ab = 1'b1; en_ba_n = 1'b1; sel_ba = 1'b0;
    a_ext_oe = 1'b1; b_ext_oe = 1'b0; a_in = 8'hE7; b_in = 8'h00;
    #0.5;
    chk("R6 pre-reset b_out", b_out, m_ab);
    #0.5 rst_n = 1'b0;
    #0.5;
    chk("R11 async clear b_out", b_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1; g_ab = 1'b1;
    @(negedge clk);
    chk("R12 first edge b_out", b_out, 8'h00);
    @(negedge clk);
    chk("R12 second edge b_out", b_out, 8'h00);
    @(negedge clk);
    g_ab = 1'b0;
    chk("R12 third edge b_out", b_out, 8'hE7);
    // Keeper loaded E7 on the same edge; read it in hold mode undriven
    sel_ab = 1'b0; en_ba_n = 1'b0; a_ext_oe = 1'b0;
    #0.5;
    chk("R9 keeper a_out", a_out, 8'hE7);
    chk("R8 keeper b_out", b_out, 8'hE7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule